// File: doc/BRIEF.md
# Freezable Two-Channel Timer Counter

The block is a free-running timer counter with two capture/compare channels. The counter's clock source is selected by a three-bit code. One setting takes the bus clock divided by a power of two. The other takes rising edges of an external clock pin, sampled and edge-detected in the bus clock domain. Each channel works either as an input capture, latching the count on a chosen pin edge, or as an output compare, driving its pin when the count reaches a programmed value. Either event sets the channel's flag.

Two control inputs freeze the block: a low-power stop request and a debug break. While either is high, the counter and the prescaler do not advance, and every register keeps its value. Counting resumes from the held count when both are low again. Input captures are suppressed while the block is frozen. Pin edges that arrive during the freeze are discarded and are not replayed afterwards. The bus decoder that writes the control fields, and the interrupt logic that consumes the flags, sit outside this block.

Top module: `frz_timer`

## Requirements
- R1: With select code k in 0..6, the count starts at 0 after reset and increments once every 2^k bus cycles. After c cycles out of reset the count is floor(c / 2^k). It wraps from all ones to 0.
- R2: With select code 7, the count increments once for each rising edge of `ext_clk`. The new value is visible by the third bus edge after the pin rises. The pin must stay high and low for at least two bus cycles each, so it runs at no more than half the bus rate.
- R3: While `stop_req` is high, the count and the prescaler phase hold. Counting resumes from the held value when `stop_req` falls.
- R4: While `brk_req` is high, the count holds. While either `brk_req` or `stop_req` is high, no channel captures or sets its flag on a pin edge. Such edges are lost after the freeze ends.
- R5: Channel mode 1 captures on a rising pin edge, mode 2 on a falling edge and mode 3 on both. A capture copies the count into `ch_cap` and sets `ch_flag` by the third bus edge after the pin changes.
- R6: Channel modes 4, 5 and 6 are output compare modes, which toggle, clear and set `ch_pin_out` respectively. The action takes effect one bus cycle after the count steps onto `ch_cmp`, and it also sets `ch_flag`. A held count does not match again.
- R7: Modes 0 and 7 disable a channel. A disabled channel, or one in a capture mode, leaves `ch_pin_out` unchanged. The two channels act independently of each other.
- R8: A one-cycle pulse on `ch_flag_clr` clears that channel's flag.
- R9: After reset, the count, every flag, every capture register and every pin output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External counter clock pin (asynchronous) |
| stop_req | input | 1 | Low-power stop request; freezes the block |
| brk_req | input | 1 | Debug break; freezes the block |
| ps_sel | input | 3 | Clock select: 0..6 divide by 2^k, 7 external pin |
| ch_mode | input | 2x3 | Per-channel mode code |
| ch_cmp | input | 2x16 | Per-channel compare value |
| ch_pin_in | input | 2 | Channel capture pins (asynchronous) |
| ch_flag_clr | input | 2 | Per-channel flag clear pulse |
| count | output | 16 | Current counter value |
| ch_pin_out | output | 2 | Channel compare outputs |
| ch_cap | output | 2x16 | Per-channel captured count |
| ch_flag | output | 2 | Per-channel event flag |

## Verification
The bench builds the block with its defaults: a 16-bit counter, two channels and a three-bit select. At that size every divide code can be swept from reset, and a wrap of the full count through zero fits in one run. In external-clock mode the count stands still between pin pulses. This lets the bench check every one of the eight channel modes against both pin edge directions, and predict each captured value exactly. The prescaler phase is checked across a break, and edges injected during a freeze are shown to be lost.

// File: rtl/frz_timer_pkg.sv
// Package: shared channel mode codes for the freezable timer.
// Assumes mode values are written by a register port outside this block.
package frz_timer_pkg;

    typedef enum logic [2:0] {
        CH_OFF       = 3'd0,
        CH_IC_RISE   = 3'd1,
        CH_IC_FALL   = 3'd2,
        CH_IC_BOTH   = 3'd3,
        CH_OC_TOGGLE = 3'd4,
        CH_OC_CLEAR  = 3'd5,
        CH_OC_SET    = 3'd6,
        CH_SPARE     = 3'd7
    } ch_mode_e;

    function automatic logic mode_is_oc(input ch_mode_e m);
        return (m == CH_OC_TOGGLE) || (m == CH_OC_CLEAR) || (m == CH_OC_SET);
    endfunction

endpackage

// File: rtl/frz_tick_gen.sv
// Module: counter enable generator.
// Produces a one-cycle tick either from a power-of-two divider of the bus
// clock or from synchronized rising edges of the external clock pin.
// Assumes the external pin runs at no more than half the bus rate.
// Nothing advances while freeze is high.
module frz_tick_gen #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            freeze,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            ext_clk,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 2;
    localparam logic [PS_W-1:0] EXT_CODE = {PS_W{1'b1}};

    logic [DIV_W-1:0] prs_q;
    logic [DIV_W-1:0] prs_mask;
    logic             ext_mode;
    logic             ext_s1, ext_s2, ext_s3;
    logic             div_hit;
    logic             ext_rise;

    assign ext_mode = (ps_sel == EXT_CODE);

    // Build the low-bit mask for the selected divide ratio.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            prs_mask[i] = (i < int'(ps_sel));
        end
    end

    assign div_hit  = ((prs_q & prs_mask) == prs_mask);
    assign ext_rise = ext_s2 & ~ext_s3;
    assign tick     = !freeze && (ext_mode ? ext_rise : div_hit);

    // Advance the divider phase on every unfrozen bus cycle in divide mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prs_q <= '0;
        end else if (!freeze && !ext_mode) begin
            prs_q <= prs_q + 1'b1;
        end
    end

    // Synchronize the external pin and keep one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_s1 <= 1'b0;
            ext_s2 <= 1'b0;
            ext_s3 <= 1'b0;
        end else begin
            ext_s1 <= ext_clk;
            ext_s2 <= ext_s1;
            ext_s3 <= ext_s2;
        end
    end

    // R2: an edge-detected external clock never ticks in two adjacent cycles
    p_ext_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && tick) |=> !(ext_mode && tick));

    // R3: a frozen divider keeps its phase
    p_prs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(prs_q));

endmodule

// File: rtl/frz_counter.sv
// Module: free-running up counter.
// Increments by one on each tick and wraps through zero. stepped marks the
// cycle after an increment so that compare logic sees each value only once.
module frz_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             freeze,
    output logic [CNT_W-1:0] count,
    output logic             stepped
);
    logic [CNT_W-1:0] count_q;
    logic             stepped_q;

    // Count ticks and record that a step happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            stepped_q <= 1'b0;
        end else begin
            stepped_q <= tick;
            if (tick) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign count   = count_q;
    assign stepped = stepped_q;

    // R3: no movement while a stop or break holds the block
    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(count_q));

    // R1: the count only ever moves by plus one (modulo wrap)
    p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_q) |-> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/frz_channel.sv
// Module: one capture/compare channel.
// In capture modes it synchronizes its pin, detects the chosen edge and
// latches the count. In compare modes it acts on the pin output when a
// freshly stepped count equals the compare value. Assumes count and stepped
// come from frz_counter and freeze is the OR of stop and break.
module frz_channel
    import frz_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] cmp,
    input  logic             pin_in,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] count,
    input  logic             stepped,
    output logic             pin_out,
    output logic [CNT_W-1:0] cap,
    output logic             flag
);
    ch_mode_e         mode_e;
    logic             pin_s1, pin_s2, pin_s3;
    logic             rise, fall;
    logic             cap_ev, cmp_ev, set_ev;
    logic             is_oc;
    logic             oc_q, flag_q;
    logic [CNT_W-1:0] cap_q;

    assign mode_e = ch_mode_e'(mode);
    assign is_oc  = mode_is_oc(mode_e);
    assign rise   = pin_s2 & ~pin_s3;
    assign fall   = ~pin_s2 & pin_s3;

    // Decide whether a pin edge qualifies for a capture in the current mode.
    always_comb begin
        unique case (mode_e)
            CH_IC_RISE: cap_ev = rise;
            CH_IC_FALL: cap_ev = fall;
            CH_IC_BOTH: cap_ev = rise | fall;
            default:    cap_ev = 1'b0;
        endcase
        if (freeze) cap_ev = 1'b0;
    end

    assign cmp_ev = is_oc && stepped && (count == cmp);
    assign set_ev = cap_ev | cmp_ev;

    // Synchronize the channel pin and keep one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_s1 <= 1'b0;
            pin_s2 <= 1'b0;
            pin_s3 <= 1'b0;
        end else begin
            pin_s1 <= pin_in;
            pin_s2 <= pin_s1;
            pin_s3 <= pin_s2;
        end
    end

    // Latch the count on a qualified capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_ev) begin
            cap_q <= count;
        end
    end

    // Drive the compare output on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q <= 1'b0;
        end else if (cmp_ev) begin
            unique case (mode_e)
                CH_OC_TOGGLE: oc_q <= ~oc_q;
                CH_OC_CLEAR:  oc_q <= 1'b0;
                CH_OC_SET:    oc_q <= 1'b1;
                default:      oc_q <= oc_q;
            endcase
        end
    end

    // Set the flag on any channel event; a clear pulse drops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign pin_out = oc_q;
    assign cap     = cap_q;
    assign flag    = flag_q;

    // R4: captured value cannot change while frozen
    p_cap_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(cap_q));

    // R7: outside compare modes the pin output holds
    p_oc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_oc |=> $stable(oc_q));

    // R8: a clear with no new event leaves the flag low
    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !set_ev) |=> !flag_q);

    // R5: a capture always raises the flag
    p_cap_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> flag_q);

endmodule

// File: rtl/frz_timer.sv
// Module: top of the freezable two-channel timer.
// Combines the clock-select tick generator, the counter and one channel per
// index. Stop and break both freeze the block; control fields are assumed
// to be held steady by the register port that drives them.
module frz_timer #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 2,
    parameter int PS_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ext_clk,
    input  logic                       stop_req,
    input  logic                       brk_req,
    input  logic [PS_W-1:0]            ps_sel,
    input  logic [N_CH-1:0][2:0]       ch_mode,
    input  logic [N_CH-1:0][CNT_W-1:0] ch_cmp,
    input  logic [N_CH-1:0]            ch_pin_in,
    input  logic [N_CH-1:0]            ch_flag_clr,
    output logic [CNT_W-1:0]           count,
    output logic [N_CH-1:0]            ch_pin_out,
    output logic [N_CH-1:0][CNT_W-1:0] ch_cap,
    output logic [N_CH-1:0]            ch_flag
);
    logic             freeze;
    logic             tick;
    logic             stepped;
    logic [CNT_W-1:0] count_w;

    assign freeze = stop_req | brk_req;

    frz_tick_gen #(.PS_W(PS_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (freeze),
        .ps_sel (ps_sel),
        .ext_clk(ext_clk),
        .tick   (tick)
    );

    frz_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .freeze (freeze),
        .count  (count_w),
        .stepped(stepped)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        frz_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .freeze  (freeze),
            .mode    (ch_mode[g]),
            .cmp     (ch_cmp[g]),
            .pin_in  (ch_pin_in[g]),
            .flag_clr(ch_flag_clr[g]),
            .count   (count_w),
            .stepped (stepped),
            .pin_out (ch_pin_out[g]),
            .cap     (ch_cap[g]),
            .flag    (ch_flag[g])
        );
    end

    assign count = count_w;

    // R9: all outputs are clear in the cycle after reset
    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && (ch_flag == '0) && (ch_pin_out == '0));

endmodule

// File: tb/test_frz_timer.sv
module test_frz_timer;
    localparam int CNT_W = 16;
    localparam int N_CH  = 2;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       ext_clk = 1'b0;
    logic                       stop_req = 1'b0;
    logic                       brk_req = 1'b0;
    logic [2:0]                 ps_sel = 3'd0;
    logic [N_CH-1:0][2:0]       ch_mode = '0;
    logic [N_CH-1:0][CNT_W-1:0] ch_cmp = '0;
    logic [N_CH-1:0]            ch_pin_in = '0;
    logic [N_CH-1:0]            ch_flag_clr = '0;
    logic [CNT_W-1:0]           count;
    logic [N_CH-1:0]            ch_pin_out;
    logic [N_CH-1:0][CNT_W-1:0] ch_cap;
    logic [N_CH-1:0]            ch_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    frz_timer i_frz_timer (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .stop_req(stop_req),
        .brk_req(brk_req), .ps_sel(ps_sel), .ch_mode(ch_mode), .ch_cmp(ch_cmp),
        .ch_pin_in(ch_pin_in), .ch_flag_clr(ch_flag_clr), .count(count),
        .ch_pin_out(ch_pin_out), .ch_cap(ch_cap), .ch_flag(ch_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ext_pulse();
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        ext_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clr_flags();
        ch_flag_clr = '1;
        @(negedge clk);
        ch_flag_clr = '0;
        @(negedge clk);
    endtask

    initial begin
        int exp_cap;
        int exp_cnt;
        repeat (3) @(negedge clk);
        chk("R9 count after reset", count, 0);
        chk("R9 flags after reset", ch_flag, 0);
        chk("R9 pins after reset", ch_pin_out, 0);
        chk("R9 capture after reset", ch_cap[0], 0);

        // R1: sweep every divide code
        for (int k = 0; k < 7; k++) begin
            ps_sel = 3'(k);
            do_reset();
            step(200);
            chk($sformatf("R1 divide code %0d", k), count, 200 >> k);
        end

        // R3: stop holds count and prescaler, then resumes
        ps_sel = 3'd0;
        do_reset();
        step(50);
        stop_req = 1'b1;
        step(20);
        chk("R3 count held during stop", count, 50);
        stop_req = 1'b0;
        step(10);
        chk("R3 count resumes after stop", count, 60);

        // R4: break holds count; divider phase kept (divide by 2)
        ps_sel = 3'd1;
        do_reset();
        step(40);
        brk_req = 1'b1;
        step(15);
        chk("R4 count held during break", count, 20);
        brk_req = 1'b0;
        step(6);
        chk("R4 count after break with kept phase", count, 23);

        // R2: external clock pulses
        ps_sel = 3'd7;
        do_reset();
        @(negedge clk);
        for (int p = 0; p < 5; p++) ext_pulse();
        step(4);
        chk("R2 external pulse count", count, 5);
        step(20);
        chk("R2 idle external pin holds count", count, 5);

        // R5, R7: every mode against both edge directions on channel 0
        ch_mode[1] = 3'd1;
        exp_cap = 0;
        exp_cnt = 5;
        for (int m = 0; m < 8; m++) begin
            ch_mode[0] = 3'(m);
            for (int e = 0; e < 2; e++) begin
                bit hit;
                ext_pulse();
                exp_cnt++;
                step(4);
                clr_flags();
                chk($sformatf("R8 flag cleared m%0d", m), ch_flag[0], 0);
                ch_pin_in[0] = (e == 0);
                step(4);
                hit = (m == 1 && e == 0) || (m == 2 && e == 1) || (m == 3);
                if (hit) exp_cap = exp_cnt;
                chk($sformatf("R5 flag mode %0d edge %0d", m, e), ch_flag[0], int'(hit));
                chk($sformatf("R5 capture mode %0d edge %0d", m, e), ch_cap[0], exp_cap);
                chk($sformatf("R7 other channel untouched m%0d", m), ch_flag[1], 0);
                chk($sformatf("R7 pin out holds m%0d", m), ch_pin_out, 0);
            end
        end

        // R4: edges during break are discarded
        ch_mode[0] = 3'd3;
        brk_req = 1'b1;
        @(negedge clk);
        ch_pin_in[0] = 1'b1;
        step(3);
        ext_pulse();
        step(4);
        chk("R4 no capture flag in break", ch_flag[0], 0);
        chk("R4 capture kept in break", ch_cap[0], exp_cap);
        chk("R4 ext edge ignored in break", count, exp_cnt);
        brk_req = 1'b0;
        step(6);
        chk("R4 break edge lost afterwards", ch_flag[0], 0);

        // R4: stop also blocks captures
        stop_req = 1'b1;
        @(negedge clk);
        ch_pin_in[0] = 1'b0;
        step(6);
        stop_req = 1'b0;
        step(4);
        chk("R4 no capture flag in stop", ch_flag[0], 0);

        // R6: compare modes at divide by 1
        ch_pin_in = '0;
        ps_sel = 3'd0;
        ch_mode[0] = 3'd4; ch_cmp[0] = 16'd20;
        ch_mode[1] = 3'd6; ch_cmp[1] = 16'd30;
        do_reset();
        step(20);
        chk("R6 toggle not yet at match", ch_pin_out[0], 0);
        step(1);
        chk("R6 toggle one cycle after match", ch_pin_out[0], 1);
        chk("R6 compare flag", ch_flag[0], 1);
        step(10);
        chk("R6 set output at match", ch_pin_out[1], 1);
        chk("R7 channels independent compare", ch_pin_out[0], 1);
        ch_mode[1] = 3'd5; ch_cmp[1] = 16'd40;
        step(9);
        chk("R6 clear output before match", ch_pin_out[1], 1);
        step(1);
        chk("R6 clear output after match", ch_pin_out[1], 0);
        ch_mode[0] = 3'd4; ch_cmp[0] = 16'd45;
        step(5);
        stop_req = 1'b1;
        step(10);
        chk("R6 no repeat match while held", ch_pin_out[0], 0);
        stop_req = 1'b0;

        // R1, R6: wrap through zero
        ch_mode = '0;
        ch_mode[0] = 3'd4; ch_cmp[0] = 16'd0;
        do_reset();
        step(65536);
        chk("R6 no toggle before zero reached", ch_pin_out[0], 0);
        step(5);
        chk("R1 count wraps", count, 5);
        chk("R6 toggle once after wrap", ch_pin_out[0], 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule